// File: doc/BRIEF.md
# Streaming rectangular matrix transposer

This block takes an unbroken stream of data words, one per clock cycle in which enable is high, and reorders it so that every matrix of `ROWS` by `COLS` words leaves in transposed order. A matrix arrives column by column and leaves row by row. One matrix follows another with no idle cycles, and the block keeps the same constant delay across matrix boundaries.

The words are held in a two-bank memory that can map onto block RAM. A write counter fills one bank while a read counter drains the bank filled one matrix earlier, and the banks swap at each matrix boundary. The delay is the smallest one the reordering permits, plus a parameter `MIN_LIFE`, which sets the shortest time any word stays in storage. When `MIN_LIFE` is 0, one word of each matrix goes straight from the input port to the output register.

Top module: `stream_transposer`

## Requirements
- R1: Within a matrix, accepted word number k (k counted from 0 and wrapping every ROWS*COLS accepted words) is the element at row k mod ROWS and column k div ROWS. Each column therefore arrives completely before the next one starts.
- R2: Once output has started, output word number q is the element at row p div COLS and column p mod COLS, where p = q mod ROWS*COLS. Its source is accepted word m*ROWS*COLS + row + ROWS*column of matrix m = q div ROWS*COLS.
- R3: The delay is D = (ROWS-1)*(COLS-1) + MIN_LIFE enabled cycles. Output word q appears in `dout` after enabled edge number q+D, with edges counted from 0 after reset. Before edge D, `dout` is 0.
- R4: A cycle with `en` low changes nothing. `dout` and all counters hold, and the stream continues correctly on the next enabled cycle.
- R5: A synchronous high `rst` clears `dout` to 0 and returns all counters to the start of a new stream.
- R6: Matrices follow one another without gaps, and storage slots are reused. Any number of consecutive matrices come out transposed without corrupting one another.
- R7: With MIN_LIFE = 0, the word whose storage time is zero appears in `dout` after the same edge at which it is accepted.
- R8: When COLS is not given it equals ROWS, so the block transposes square matrices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the stream by one word when high |
| din | input | WORD | Input word |
| dout | output | WORD | Registered output word |

## Verification
The hardest case to reach is a word read from a slot in the same cycle another word is written. In the zero-lifetime setting this happens with the same slot, and the block must forward the incoming word. With the default setting it happens with a slot of the other bank just before that slot is overwritten. The stimulus streams five to six back-to-back matrices through each configuration, so every slot is reused several times. It inserts enable gaps in the middle of matrices, and it applies a reset partway through a stream before starting a new one.

// File: rtl/st_pkg.sv
package st_pkg;
  // Smallest delay that lets every output word exist before it is needed,
  // plus the extra storage time requested.
  function automatic int st_delay(input int rows, input int cols, input int min_life);
    return (rows - 1) * (cols - 1) + min_life;
  endfunction

  // A two-bank store holds words safely only below this extra lifetime.
  function automatic int st_life_limit(input int rows, input int cols);
    return 2 * (rows + cols - 1);
  endfunction
endpackage

// File: rtl/st_wr_ctrl.sv
module st_wr_ctrl #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [IW-1:0] w_idx,
  output logic          w_bank
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      w_idx  <= '0;
      w_bank <= 1'b0;
    end else if (en) begin
      if (w_idx == LAST) begin
        w_idx  <= '0;
        w_bank <= ~w_bank;
      end else begin
        w_idx <= w_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/st_rd_ctrl.sv
module st_rd_ctrl #(
  parameter int ROWS  = 4,
  parameter int COLS  = 8,
  parameter int DELAY = 23,
  parameter int IW    = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  output logic                    active,
  output logic [IW-1:0]           r_idx,
  output logic                    r_bank,
  output logic [$clog2(ROWS)-1:0] r_row,
  output logic [$clog2(COLS)-1:0] r_col
);
  localparam int RW  = $clog2(ROWS);
  localparam int CLW = $clog2(COLS);
  localparam int FW  = $clog2(DELAY + 1);
  localparam logic [FW-1:0]  FILL_END = FW'(DELAY);
  localparam logic [RW-1:0]  ROW_END  = RW'(ROWS - 1);
  localparam logic [CLW-1:0] COL_END  = CLW'(COLS - 1);
  localparam logic [IW-1:0]  STEP     = IW'(ROWS);

  logic [FW-1:0] fill;

  assign active = (fill == FILL_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      fill   <= '0;
      r_idx  <= '0;
      r_bank <= 1'b0;
      r_row  <= '0;
      r_col  <= '0;
    end else if (en) begin
      if (!active) begin
        fill <= fill + 1'b1;
      end else if (r_col == COL_END) begin
        r_col <= '0;
        if (r_row == ROW_END) begin
          r_row  <= '0;
          r_idx  <= '0;
          r_bank <= ~r_bank;
        end else begin
          r_row <= r_row + 1'b1;
          r_idx <= IW'(r_row) + 1'b1;
        end
      end else begin
        r_col <= r_col + 1'b1;
        r_idx <= r_idx + STEP;
      end
    end
  end
endmodule

// File: rtl/st_store.sv
module st_store #(
  parameter int WORD = 16,
  parameter int N    = 32,
  parameter int IW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [WORD-1:0] din,
  input  logic [IW-1:0]   w_idx,
  input  logic            w_bank,
  input  logic            rd_en,
  input  logic [IW-1:0]   r_idx,
  input  logic            r_bank,
  output logic [WORD-1:0] dout
);
  localparam int DEPTH = 2 * N;
  localparam int AW    = $clog2(DEPTH);

  logic [WORD-1:0] mem [DEPTH];
  logic [AW-1:0]   waddr, raddr;
  logic            fwd;

  assign waddr = (w_bank ? AW'(N) : AW'(0)) + AW'(w_idx);
  assign raddr = (r_bank ? AW'(N) : AW'(0)) + AW'(r_idx);
  assign fwd   = (waddr == raddr);

  always_ff @(posedge clk) begin
    if (en) mem[waddr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else if (en && rd_en) dout <= fwd ? din : mem[raddr];
  end
endmodule

// File: rtl/stream_transposer.sv
module stream_transposer #(
  parameter int WORD     = 16,
  parameter int ROWS     = 4,
  parameter int COLS     = ROWS,
  parameter int MIN_LIFE = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [WORD-1:0] din,
  output logic [WORD-1:0] dout
);
  localparam int N     = ROWS * COLS;
  localparam int IW    = $clog2(N);
  localparam int DELAY = st_pkg::st_delay(ROWS, COLS, MIN_LIFE);

  logic [IW-1:0]           w_idx, r_idx;
  logic                    w_bank, r_bank, active;
  logic [$clog2(ROWS)-1:0] r_row;
  logic [$clog2(COLS)-1:0] r_col;

  st_wr_ctrl #(.N(N), .IW(IW)) u_wr (
    .clk(clk), .rst(rst), .en(en), .w_idx(w_idx), .w_bank(w_bank)
  );

  st_rd_ctrl #(.ROWS(ROWS), .COLS(COLS), .DELAY(DELAY), .IW(IW)) u_rd (
    .clk(clk), .rst(rst), .en(en), .active(active), .r_idx(r_idx),
    .r_bank(r_bank), .r_row(r_row), .r_col(r_col)
  );

  st_store #(.WORD(WORD), .N(N), .IW(IW)) u_mem (
    .clk(clk), .rst(rst), .en(en), .din(din), .w_idx(w_idx), .w_bank(w_bank),
    .rd_en(active), .r_idx(r_idx), .r_bank(r_bank), .dout(dout)
  );
endmodule

// File: rtl/st_checker.sv
module st_checker #(
  parameter int WORD     = 16,
  parameter int ROWS     = 4,
  parameter int COLS     = 4,
  parameter int MIN_LIFE = 0
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [WORD-1:0]         dout,
  input logic                    active,
  input logic [$clog2(ROWS*COLS)-1:0] w_idx,
  input logic                    w_bank,
  input logic [$clog2(COLS)-1:0] r_col
);
  localparam int N     = ROWS * COLS;
  localparam int DELAY = st_pkg::st_delay(ROWS, COLS, MIN_LIFE);

  int   ecnt;
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) ecnt <= 0;
    else if (en && ecnt < DELAY) ecnt <= ecnt + 1;
  end

  initial begin
    p_life_limit_r3: assert (MIN_LIFE < st_pkg::st_life_limit(ROWS, COLS));
  end

  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    (ecnt == DELAY) == active);

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !active |-> dout == '0);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dout) && $stable(w_idx) && $stable(r_col));

  p_reset_clear_r5: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> dout == '0 && w_idx == '0 && !active);

  p_bank_swap_r6: assert property (@(posedge clk) disable iff (rst)
    en && w_idx == ($clog2(N))'(N - 1) |=> w_idx == '0 && w_bank != $past(w_bank));

  p_col_step_r2: assert property (@(posedge clk) disable iff (rst)
    en && active && r_col != ($clog2(COLS))'(COLS - 1) |=> r_col == $past(r_col) + 1'b1);
endmodule

bind stream_transposer st_checker #(
  .WORD(WORD), .ROWS(ROWS), .COLS(COLS), .MIN_LIFE(MIN_LIFE)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .dout(dout), .active(active),
  .w_idx(w_idx), .w_bank(w_bank), .r_col(r_col)
);

// File: tb/tb_stream_transposer.sv
module tb_stream_transposer;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int RA = 4, CA = 8, LA = 2;
  localparam int RB = 3, CB = 3, LB = 0;
  localparam int DA = (RA - 1) * (CA - 1) + LA;
  localparam int DB = (RB - 1) * (CB - 1) + LB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_a = 1'b0, en_b = 1'b0;
  logic [W-1:0] din_a = '0, din_b = '0;
  logic [W-1:0] dout_a, dout_b;

  int tests = 0, fails = 0, sa = 0, sb = 0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  stream_transposer #(.WORD(W), .ROWS(RA), .COLS(CA), .MIN_LIFE(LA)) dut (
    .clk(clk), .rst(rst), .en(en_a), .din(din_a), .dout(dout_a)
  );

  // COLS left at its default (R8)
  stream_transposer #(.WORD(W), .ROWS(RB), .MIN_LIFE(LB)) dut_sq (
    .clk(clk), .rst(rst), .en(en_b), .din(din_b), .dout(dout_b)
  );

  function automatic logic [W-1:0] val(input int s);
    return W'(s * 7 + 3);
  endfunction

  // Accepted-word number feeding output edge s, or -1 before output starts.
  function automatic int src(input int s, input int r, input int c, input int d);
    int q, m, p;
    if (s < d) return -1;
    q = s - d; m = q / (r * c); p = q % (r * c);
    return m * r * c + (p / c) + r * (p % c);
  endfunction

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] expv, input string tag);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // Driver pushes expected value, monitor side pops after the edge.
  task automatic step(input int which, input logic e);
    logic [W-1:0] prev;
    int k;
    @(negedge clk);
    prev = (which == 0) ? dout_a : dout_b;
    if (which == 0) begin
      en_a = e; din_a = val(sa); en_b = 1'b0;
      k = src(sa, RA, CA, DA);
      if (e) begin
        exp_q.push_back(k < 0 ? '0 : val(k));
        tag_q.push_back(k < 0 ? "R3" : (sa - DA >= 2 * RA * CA) ? "R6 R2" : "R1 R2 R3");
      end
    end else begin
      en_b = e; din_b = val(sb); en_a = 1'b0;
      k = src(sb, RB, CB, DB);
      if (e) begin
        exp_q.push_back(k < 0 ? '0 : val(k));
        tag_q.push_back(k < 0 ? "R3 R8" : (k == sb) ? "R7" : "R8 R2 R6");
      end
    end
    @(posedge clk);
    #1;
    if (e) begin
      check((which == 0) ? dout_a : dout_b, exp_q.pop_front(), tag_q.pop_front());
      if (which == 0) sa++; else sb++;
    end else begin
      check((which == 0) ? dout_a : dout_b, prev, "R4");
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en_a = 1'b0; en_b = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    sa = 0; sb = 0;
    exp_q.delete(); tag_q.delete();
    check(dout_a, '0, "R5");
    check(dout_b, '0, "R5");
  endtask

  initial begin
    do_reset();
    // Default configuration: long run with enable gaps mid-matrix
    for (int i = 0; i < 220; i++)
      step(0, !(i >= 60 && i < 120 && (i % 5) == 2));
    // Reset partway through a stream, then restart
    for (int i = 0; i < 10; i++) step(0, 1'b1);
    do_reset();
    for (int i = 0; i < 60; i++) step(0, 1'b1);
    // Square zero-lifetime configuration
    for (int i = 0; i < 70; i++) step(1, (i % 11) != 5);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule